// File: doc/BRIEF.md
# I2C Slave Register Front End for a Four-Channel Digital Potentiometer

This block is the serial side of a four-channel digital potentiometer. It watches an I2C bus through a two-flop synchronizer on each line and recognises START and STOP. It answers only to an address byte made of a fixed device prefix followed by four strap pins. After the address comes an instruction byte that picks an operation, one of four storage registers and one of four pots. Each pot has an 8-bit wiper register that takes effect at once and four 8-bit storage registers that model non-volatile cells.

A write to a storage register does not land on the data acknowledge. It is held until the STOP and then starts a programming cycle of fixed length. During that cycle the block is deaf to the bus and does not acknowledge even its own address, so a master finds out that programming has finished by polling. An active-low write-protect input blocks storage writes. When it is low, the data byte of such a write is refused, and a pending write is dropped if the input falls before the STOP. Reads stream the selected storage register MSB first for as long as the master acknowledges.

Top module: `i2c_pot_slave`

## Requirements
- R1: The block ignores the bus until a START (SDA falling while SCL is high). A STOP (SDA rising while SCL is high) always returns it to idle. Bytes clocked without a preceding START get no acknowledge.
- R2: The address byte must equal 0101 in bits 7..4 and `strap_addr` in bits 3..0. Only a full match is acknowledged, and any mismatch is left unacknowledged.
- R3: Instruction byte layout: bits 7..4 opcode, bits 3..2 storage register select, bits 1..0 pot select. The opcodes are 1001 read storage, 1100 write storage, 1010 write wiper and 1101 copy storage to wiper. Any other opcode is not acknowledged and has no effect.
- R4: Each accepted byte is acknowledged by holding SDA low through the ninth SCL clock. The block changes its SDA drive only while SCL is low.
- R5: A storage write commits at the STOP, not at the data acknowledge. `busy` is then high for exactly PROG_CYCLES clock cycles, and it rises only after such a commit.
- R6: While `busy` is high the block drives no acknowledge, not even to its own address. The first address after `busy` falls is acknowledged again.
- R7: With `wp_n` low, the address and instruction of a storage write are acknowledged but the data byte is not, and the register is unchanged. If `wp_n` falls after the data byte but before the STOP, the write is dropped. If it falls after programming has begun, the write completes.
- R8: A read sends the selected storage register MSB first and then releases SDA. After a master acknowledge it sends the byte again. After a master not-acknowledge it stops driving and waits for STOP.
- R9: A wiper write updates `wiper_q` for that pot when the data byte is accepted, without raising `busy`. A copy instruction loads the pot's wiper from the selected storage register.
- R10: After reset every wiper and storage register is zero, `busy` is low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_addr | input | 4 | Board-strapped low nibble of the device address |
| wp_n | input | 1 | Active-low write protect for storage registers |
| busy | output | 1 | High while a storage programming cycle runs |
| wiper_q | output | 32 | Wiper values, pot p in bits 8p+7..8p |

## Verification
The bound checker watches four things on every cycle. SDA drive never changes while SCL is high. No acknowledge is driven while `busy` is high. `busy` only rises after a storage commit, and it lasts exactly the programmed length. A commit only happens when write protect was high. Address matching, opcode decoding, the protected data byte going unacknowledged, dropping a pending write when protect falls before the STOP, the deferred commit and the read streaming under master ACK and NACK can only be shown by the bench. It does so through whole bus transactions, reading the storage registers back over the bus.

// File: rtl/i2c_pot_pkg.sv
package i2c_pot_pkg;

    localparam int POT_W = 2;
    localparam int REG_W = 2;
    localparam int NPOT  = 1 << POT_W;
    localparam int NREG  = 1 << REG_W;
    localparam int DW    = 8;

    localparam logic [3:0] DEV_PREFIX = 4'b0101;

    localparam logic [3:0] OP_RD_STORE = 4'b1001;
    localparam logic [3:0] OP_WR_STORE = 4'b1100;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_COPY     = 4'b1101;

    typedef struct packed {
        logic [3:0]       op;
        logic [REG_W-1:0] rsel;
        logic [POT_W-1:0] psel;
    } instr_t;

    typedef struct packed {
        logic             valid;
        logic [POT_W-1:0] pot;
        logic [REG_W-1:0] rsel;
        logic [DW-1:0]    data;
    } nvreq_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_ACKWAIT, S_ACK, S_TX, S_TXACK, S_TXNEXT, S_IGNORE
    } bit_state_e;

    typedef enum logic [1:0] {PH_ADDR, PH_INST, PH_DATA} phase_e;

    typedef enum logic [1:0] {AF_RX, AF_TX, AF_IGN} after_ack_e;

    function automatic logic addr_hit(input logic [7:0] b, input logic [3:0] strap);
        return b == {DEV_PREFIX, strap};
    endfunction

endpackage

// File: rtl/i2c_pot_sync.sv
module i2c_pot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic scl_s, scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign scl_p = scl_pipe[STAGES];
    assign sda_s = sda_pipe[STAGES-1];
    assign sda_p = sda_pipe[STAGES];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_pot_engine.sv
module i2c_pot_engine
    import i2c_pot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [3:0]       strap,
    input  logic             wp_n,
    input  logic             busy,
    input  logic [DW-1:0]    rd_data,
    output logic             drive_low,
    output logic [POT_W-1:0] sel_pot,
    output logic [REG_W-1:0] sel_reg,
    output logic             wip_we,
    output logic             copy_we,
    output logic             nv_commit,
    output logic [POT_W-1:0] cmd_pot,
    output logic [REG_W-1:0] cmd_reg,
    output logic [DW-1:0]    cmd_data
);
    bit_state_e st;
    phase_e     ph;
    after_ack_e after;
    logic [3:0] cnt;
    logic [7:0] shreg;
    instr_t     instr;
    nvreq_t     pend;
    logic [7:0] nb;
    instr_t     nb_i;

    assign nb      = {shreg[6:0], sda_s};
    assign nb_i    = nb;
    assign sel_pot = instr.psel;
    assign sel_reg = instr.rsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            ph        <= PH_ADDR;
            after     <= AF_IGN;
            cnt       <= '0;
            shreg     <= '0;
            instr     <= '0;
            pend      <= '0;
            drive_low <= 1'b0;
            wip_we    <= 1'b0;
            copy_we   <= 1'b0;
            nv_commit <= 1'b0;
            cmd_pot   <= '0;
            cmd_reg   <= '0;
            cmd_data  <= '0;
        end else begin
            wip_we    <= 1'b0;
            copy_we   <= 1'b0;
            nv_commit <= 1'b0;
            if (stop_det) begin
                st        <= S_IDLE;
                drive_low <= 1'b0;
                if (pend.valid && wp_n) begin
                    nv_commit <= 1'b1;
                    cmd_pot   <= pend.pot;
                    cmd_reg   <= pend.rsel;
                    cmd_data  <= pend.data;
                end
                pend.valid <= 1'b0;
            end else if (start_det) begin
                drive_low  <= 1'b0;
                pend.valid <= 1'b0;
                cnt        <= '0;
                ph         <= PH_ADDR;
                st         <= busy ? S_IDLE : S_RX;
            end else begin
                case (st)
                    S_RX: if (scl_rise) begin
                        shreg <= nb;
                        if (cnt == 4'd7) begin
                            cnt <= '0;
                            st  <= S_IGNORE;
                            case (ph)
                                PH_ADDR: if (addr_hit(nb, strap)) begin
                                    st    <= S_ACKWAIT;
                                    after <= AF_RX;
                                    ph    <= PH_INST;
                                end
                                PH_INST: begin
                                    instr <= nb_i;
                                    if (nb_i.op == OP_RD_STORE) begin
                                        st    <= S_ACKWAIT;
                                        after <= AF_TX;
                                    end else if (nb_i.op == OP_WR_STORE || nb_i.op == OP_WR_WIPER) begin
                                        st    <= S_ACKWAIT;
                                        after <= AF_RX;
                                        ph    <= PH_DATA;
                                    end else if (nb_i.op == OP_COPY) begin
                                        st      <= S_ACKWAIT;
                                        after   <= AF_IGN;
                                        copy_we <= 1'b1;
                                        cmd_pot <= nb_i.psel;
                                        cmd_reg <= nb_i.rsel;
                                    end
                                end
                                default: begin
                                    if (instr.op == OP_WR_WIPER) begin
                                        wip_we   <= 1'b1;
                                        cmd_pot  <= instr.psel;
                                        cmd_data <= nb;
                                        st       <= S_ACKWAIT;
                                        after    <= AF_IGN;
                                    end else if (wp_n) begin
                                        pend  <= '{valid: 1'b1, pot: instr.psel,
                                                   rsel: instr.rsel, data: nb};
                                        st    <= S_ACKWAIT;
                                        after <= AF_IGN;
                                    end
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 4'd1;
                        end
                    end
                    S_ACKWAIT: if (scl_fall) begin
                        drive_low <= 1'b1;
                        st        <= S_ACK;
                    end
                    S_ACK: if (scl_fall) begin
                        cnt <= '0;
                        case (after)
                            AF_RX: begin
                                drive_low <= 1'b0;
                                st        <= S_RX;
                            end
                            AF_TX: begin
                                shreg     <= rd_data;
                                drive_low <= ~rd_data[7];
                                st        <= S_TX;
                            end
                            default: begin
                                drive_low <= 1'b0;
                                st        <= S_IGNORE;
                            end
                        endcase
                    end
                    S_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                drive_low <= 1'b0;
                                cnt       <= '0;
                                st        <= S_TXACK;
                            end else begin
                                shreg     <= {shreg[6:0], 1'b0};
                                drive_low <= ~shreg[6];
                            end
                        end
                    end
                    S_TXACK: if (scl_rise) begin
                        st <= sda_s ? S_IGNORE : S_TXNEXT;
                    end
                    S_TXNEXT: if (scl_fall) begin
                        shreg     <= rd_data;
                        drive_low <= ~rd_data[7];
                        cnt       <= '0;
                        st        <= S_TX;
                    end
                    default: ;
                endcase
                if (!wp_n) pend.valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_pot_regfile.sv
module i2c_pot_regfile
    import i2c_pot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wip_we,
    input  logic               copy_we,
    input  logic               nv_we,
    input  logic [POT_W-1:0]   cmd_pot,
    input  logic [REG_W-1:0]   cmd_reg,
    input  logic [DW-1:0]      cmd_data,
    input  logic [POT_W-1:0]   sel_pot,
    input  logic [REG_W-1:0]   sel_reg,
    output logic [DW-1:0]      rd_data,
    output logic [NPOT*DW-1:0] wiper_flat
);
    logic [NPOT*NREG*DW-1:0]  store_flat;
    logic [POT_W+REG_W-1:0]   rd_idx;

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        logic [DW-1:0] wip_r;
        logic [DW-1:0] st_r [NREG];
        logic          hit;

        assign hit = (cmd_pot == POT_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                wip_r <= '0;
                for (int r = 0; r < NREG; r++) st_r[r] <= '0;
            end else begin
                if (wip_we && hit)       wip_r <= cmd_data;
                else if (copy_we && hit) wip_r <= st_r[cmd_reg];
                for (int r = 0; r < NREG; r++) begin
                    if (nv_we && hit && cmd_reg == REG_W'(r)) st_r[r] <= cmd_data;
                end
            end
        end

        assign wiper_flat[p*DW +: DW] = wip_r;
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            assign store_flat[(p*NREG + r)*DW +: DW] = st_r[r];
        end
    end

    assign rd_idx  = {sel_pot, sel_reg};
    assign rd_data = store_flat[rd_idx*DW +: DW];
endmodule

// File: rtl/i2c_pot_timer.sv
module i2c_pot_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (start)       left <= CW'(PROG_CYCLES);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/i2c_pot_slave.sv
module i2c_pot_slave
    import i2c_pot_pkg::*;
#(
    parameter int PROG_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [3:0]         strap_addr,
    input  logic               wp_n,
    output logic               busy,
    output logic [NPOT*DW-1:0] wiper_q
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wip_we, copy_we, nv_commit;
    logic [POT_W-1:0] sel_pot, cmd_pot;
    logic [REG_W-1:0] sel_reg, cmd_reg;
    logic [DW-1:0]    cmd_data, rd_data;

    i2c_pot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_pot_engine u_eng (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap(strap_addr), .wp_n(wp_n), .busy(busy), .rd_data(rd_data),
        .drive_low(sda_oe), .sel_pot(sel_pot), .sel_reg(sel_reg),
        .wip_we(wip_we), .copy_we(copy_we), .nv_commit(nv_commit),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data)
    );

    i2c_pot_regfile u_rf (
        .clk(clk), .rst(rst), .wip_we(wip_we), .copy_we(copy_we),
        .nv_we(nv_commit), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg),
        .cmd_data(cmd_data), .sel_pot(sel_pot), .sel_reg(sel_reg),
        .rd_data(rd_data), .wiper_flat(wiper_q)
    );

    i2c_pot_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(nv_commit), .busy(busy)
    );
endmodule

// File: rtl/i2c_pot_slave_chk.sv
module i2c_pot_slave_chk #(
    parameter int PROG_CYCLES = 1000
) (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_oe,
    input logic busy,
    input logic wp_n,
    input logic nv_commit
);
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_len <= 0;
        else              busy_len <= busy_len + 1;
    end

    a_r4_sda_only_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_len == PROG_CYCLES);

    a_r5_busy_after_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(nv_commit));

    a_r7_commit_needs_wp: assert property (@(posedge clk) disable iff (rst)
        nv_commit |-> $past(wp_n));
endmodule

bind i2c_pot_slave i2c_pot_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .busy(busy), .wp_n(wp_n), .nv_commit(nv_commit)
);

// File: tb/i2c_pot_slave_tb.sv
module i2c_pot_slave_tb;
    localparam int Q = 25;
    localparam logic [3:0] STRAP = 4'b1011;
    localparam logic [7:0] ADDR  = {4'b0101, STRAP};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp_n  = 1'b1;
    logic sda_oe, busy;
    logic [31:0] wiper_q;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    string exp_tag[$];
    int    exp_val[$];
    int    obs_val[$];

    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_pot_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_addr(STRAP), .wp_n(wp_n), .busy(busy), .wiper_q(wiper_q)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_item(input string req, input int v);
        exp_tag.push_back(req);
        exp_val.push_back(v);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        obs_val.push_back(sda_line ? 0 : 1);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic master_ack);
        logic [7:0] b;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0;
        end
        obs_val.push_back(int'(b));
        tick(Q);
        m_sda = ~master_ack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic wr_txn(input string req, input logic [7:0] inst,
                          input logic [7:0] data, input int ack_data);
        bus_start;
        expect_item(req, 1); send_byte(ADDR);
        expect_item(req, 1); send_byte(inst);
        expect_item(req, ack_data); send_byte(data);
    endtask

    task automatic read_back(input string req, input logic [7:0] inst, input int v);
        bus_start;
        expect_item(req, 1); send_byte(ADDR);
        expect_item(req, 1); send_byte(inst);
        expect_item(req, v); recv_byte(1'b0);
        bus_stop;
    endtask

    task automatic finish_run;
        wait (obs_val.size() == 0);
        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : monitor
        forever begin
            wait (obs_val.size() != 0);
            n_chk++;
            if (exp_val.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected item actual=%0h expected=none", obs_val[0]);
                void'(obs_val.pop_front());
            end else begin
                string t;
                int e, a;
                t = exp_tag.pop_front();
                e = exp_val.pop_front();
                a = obs_val.pop_front();
                if (a != e) begin
                    n_fail++;
                    $display("FAIL %s actual=%0h expected=%0h", t, a, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        tick(6);
        rst = 1'b0;
        tick(4);
        // R10: reset state
        check("R10 busy", int'(busy), 0);
        check("R10 sda", int'(sda_oe), 0);
        check("R10 wipers", int'(wiper_q), 0);

        // R1: bytes without a START are ignored
        m_scl = 1'b0; tick(Q);
        expect_item("R1 no start", 0); send_byte(ADDR);
        bus_stop;

        // R2: wrong strap nibble is not acknowledged
        bus_start;
        expect_item("R2 addr mismatch", 0); send_byte({4'b0101, 4'b1010});
        bus_stop;
        bus_start;
        expect_item("R2 prefix mismatch", 0); send_byte({4'b0110, STRAP});
        bus_stop;

        // R9 / R4: wiper write, pot 2
        wr_txn("R4 wiper write ack", 8'b1010_00_10, 8'hA5, 1);
        bus_stop;
        check("R9 wiper2", int'(wiper_q[16 +: 8]), 8'hA5);
        check("R9 busy stays low", int'(busy), 0);

        // R5 / R6: storage write pot1 reg3, then poll
        wr_txn("R5 store write", 8'b1100_11_01, 8'h3C, 1);
        check("R5 no busy before STOP", int'(busy), 0);
        bus_stop;
        check("R5 busy after STOP", int'(busy), 1);
        bus_start;
        expect_item("R6 poll while busy", 0); send_byte(ADDR);
        bus_stop;
        wait (busy == 1'b0);
        tick(4);
        bus_start;
        expect_item("R6 poll after busy", 1); send_byte(ADDR);
        bus_stop;

        // R8: read with ACK then NACK
        bus_start;
        expect_item("R8 addr", 1); send_byte(ADDR);
        expect_item("R8 inst", 1); send_byte(8'b1001_11_01);
        expect_item("R8 first byte", 8'h3C); recv_byte(1'b1);
        expect_item("R8 repeat byte", 8'h3C); recv_byte(1'b0);
        check("R8 released after NACK", int'(sda_oe), 0);
        bus_stop;

        // R3: field positions, pot 2 reg 1 versus pot 1 reg 2
        wr_txn("R3 write p2r1", 8'b1100_01_10, 8'h12, 1);
        bus_stop;
        wait (busy == 1'b0); tick(4);
        wr_txn("R3 write p1r2", 8'b1100_10_01, 8'h21, 1);
        bus_stop;
        wait (busy == 1'b0); tick(4);
        read_back("R3 read p2r1", 8'b1001_01_10, 8'h12);
        read_back("R3 read p1r2", 8'b1001_10_01, 8'h21);

        // R9: copy pot1 reg3 into wiper 1
        bus_start;
        expect_item("R9 copy addr", 1); send_byte(ADDR);
        expect_item("R9 copy inst", 1); send_byte(8'b1101_11_01);
        bus_stop;
        check("R9 wiper1 copied", int'(wiper_q[8 +: 8]), 8'h3C);

        // R3: unknown opcode
        bus_start;
        expect_item("R3 addr", 1); send_byte(ADDR);
        expect_item("R3 bad opcode", 0); send_byte(8'b0000_00_00);
        bus_stop;
        check("R3 bad opcode no busy", int'(busy), 0);

        // R7: protected write refused
        wp_n = 1'b0;
        wr_txn("R7 protected", 8'b1100_00_00, 8'h77, 0);
        bus_stop;
        check("R7 no busy when protected", int'(busy), 0);
        wp_n = 1'b1;
        read_back("R7 reg unchanged", 8'b1001_00_00, 8'h00);

        // R7: protect falls before STOP
        wr_txn("R7 cancel", 8'b1100_01_00, 8'h55, 1);
        wp_n = 1'b0; tick(Q);
        bus_stop;
        check("R7 cancel no busy", int'(busy), 0);
        wp_n = 1'b1;
        read_back("R7 cancelled value", 8'b1001_01_00, 8'h00);

        // R7: protect falls after programming began
        wr_txn("R7 late protect", 8'b1100_10_00, 8'h99, 1);
        bus_stop;
        wp_n = 1'b0;
        check("R7 busy runs", int'(busy), 1);
        wait (busy == 1'b0); tick(4);
        wp_n = 1'b1;
        read_back("R7 late protect value", 8'b1001_10_00, 8'h99);

        finish_run;
    end
endmodule